// File: doc/BRIEF.md
# Variable Page-Size Translation Buffer

This block is a small, fully associative address translation cache. Each of its entries covers a pair of neighbouring virtual pages that share one tag. The entry holds two frame records, one for the even page of the pair and one for the odd page. Each entry also carries a mask that sets the page size. There are seven sizes, from 4 KB up to 16 MB in steps of four.

Software loads the block through four staging registers: mask, tag, even frame and odd frame. It fills them over a register-style port and then issues a write to an index of its choice. A read command does the reverse and copies an entry back into the staging registers.

A separate lookup port takes a virtual address and answers in the same cycle. It returns a hit flag, a valid flag for the selected frame, and the translated physical address.

Top module: `vpt_tlb`

## Requirements
- R1: While reset is asserted, every staging register is cleared. Every entry is set to tag 0, mask 0 and both frames invalid with frame number 0. As a result, right after reset an address in the lowest 8 KB reports hit=1, valid=0, and an address with bit 31 set reports a miss.
- R2: The staging port selects a register with `cfg_sel`: 0 is the mask, 1 is the tag, 2 is the even frame and 3 is the odd frame. The mask sits at data bits 24:13. The tag sits at bits 31:13. A frame holds its frame number at bits 20:1 and its valid flag at bit 0. `cfg_we` writes the selected register on the clock edge. `cfg_rdata` shows the selected register at once, with every bit outside its fields reading 0.
- R3: `tlb_wr` copies all four staging registers into entry `tlb_idx` on the clock edge. The staging registers hold their values unless the port writes them or a read loads them.
- R4: `tlb_rd` copies entry `tlb_idx` into the staging registers on the clock edge. If `cfg_we` is asserted in the same cycle, the read wins.
- R5: An entry matches when address bits 31:13 equal its tag, except that each address bit 13+j with mask bit j set is left out of the compare. The only masks used are the low 0, 2, 4, 6, 8, 10 or 12 bits set.
- R6: The page of the pair is chosen by address bit 12+n, where n is the number of mask bits set. A 0 on that bit selects the even frame and a 1 selects the odd frame.
- R7: On a hit, physical address bits 11:0, and bit 12+j for each set mask bit j, come straight from the virtual address. Every other bit comes from the selected frame number shifted left by 12.
- R8: A hit whose selected frame is invalid reports hit=1 and valid=0. `lk_valid` is never 1 without `lk_hit`.
- R9: On a miss, hit, valid and the physical address are all 0.
- R10: When several entries match, the one with the lowest index supplies the result.
- R11: Lookup is combinational. An entry written on a clock edge affects the lookup outputs straight after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write the selected staging register |
| cfg_sel | input | 2 | Staging register select |
| cfg_wdata | input | 32 | Staging write data |
| cfg_rdata | output | 32 | Selected staging register, fields in place |
| tlb_wr | input | 1 | Load entry `tlb_idx` from staging |
| tlb_rd | input | 1 | Load staging from entry `tlb_idx` |
| tlb_idx | input | 3 | Entry index for read and write |
| lk_va | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Some entry matched |
| lk_valid | output | 1 | The selected frame is valid |
| lk_pa | output | 32 | Translated physical address |

## Verification
A corrupted tag or mask bit in an entry shows up in the same cycle on the lookup port. Addresses that should fall in that entry's pair then miss, or land on a neighbour's frame. Bits that the mask should ignore only show when the sweep varies them, so the sweeps cover every page size with randomized bits below each pair boundary.

A wrong even/odd choice or a wrong offset width shows in the physical address only at page boundaries. The directed lookups therefore probe the first and last byte of each page. Staging and entry storage faults show one cycle after a read command, through the readback port. A priority fault stays hidden until two entries overlap, which the bench sets up on purpose.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
   // fixed address layout of the translation scheme
   localparam int unsigned PG_OFF_W = 12;   // smallest page offset
   localparam int unsigned MSK_LSB  = 13;   // first maskable address bit
   localparam int unsigned MSK_W    = 12;   // maskable bits 24:13

   typedef enum logic [1:0] {
      STG_MASK = 2'd0,
      STG_TAG  = 2'd1,
      STG_EVEN = 2'd2,
      STG_ODD  = 2'd3
   } stg_sel_e;
endpackage

// File: rtl/vpt_stage.sv
module vpt_stage
   import vpt_pkg::*;
#(
   parameter int unsigned VA_W  = 32,
   parameter int unsigned PFN_W = 20,
   localparam int unsigned TAG_W = VA_W - MSK_LSB
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_sel,
   input  logic [VA_W-1:0]    cfg_wdata,
   output logic [VA_W-1:0]    cfg_rdata,
   input  logic               ld_en,
   input  logic [MSK_W-1:0]   ld_mask,
   input  logic [TAG_W-1:0]   ld_tag,
   input  logic [PFN_W-1:0]   ld_epfn,
   input  logic               ld_ev,
   input  logic [PFN_W-1:0]   ld_opfn,
   input  logic               ld_ov,
   output logic [MSK_W-1:0]   stg_mask,
   output logic [TAG_W-1:0]   stg_tag,
   output logic [PFN_W-1:0]   stg_epfn,
   output logic               stg_ev,
   output logic [PFN_W-1:0]   stg_opfn,
   output logic               stg_ov
);
   stg_sel_e sel;
   assign sel = stg_sel_e'(cfg_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_mask <= '0;
         stg_tag  <= '0;
         stg_epfn <= '0;
         stg_ev   <= 1'b0;
         stg_opfn <= '0;
         stg_ov   <= 1'b0;
      end else if (ld_en) begin
         // an entry read has priority over a port write
         stg_mask <= ld_mask;
         stg_tag  <= ld_tag;
         stg_epfn <= ld_epfn;
         stg_ev   <= ld_ev;
         stg_opfn <= ld_opfn;
         stg_ov   <= ld_ov;
      end else if (cfg_we) begin
         unique case (sel)
            STG_MASK: stg_mask <= cfg_wdata[MSK_LSB +: MSK_W];
            STG_TAG:  stg_tag  <= cfg_wdata[VA_W-1:MSK_LSB];
            STG_EVEN: begin
               stg_epfn <= cfg_wdata[PFN_W:1];
               stg_ev   <= cfg_wdata[0];
            end
            STG_ODD: begin
               stg_opfn <= cfg_wdata[PFN_W:1];
               stg_ov   <= cfg_wdata[0];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      cfg_rdata = '0;
      unique case (sel)
         STG_MASK: cfg_rdata[MSK_LSB +: MSK_W] = stg_mask;
         STG_TAG:  cfg_rdata[VA_W-1:MSK_LSB]   = stg_tag;
         STG_EVEN: begin
            cfg_rdata[PFN_W:1] = stg_epfn;
            cfg_rdata[0]       = stg_ev;
         end
         STG_ODD: begin
            cfg_rdata[PFN_W:1] = stg_opfn;
            cfg_rdata[0]       = stg_ov;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/vpt_bank.sv
module vpt_bank
   import vpt_pkg::*;
#(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned VA_W    = 32,
   parameter int unsigned PFN_W   = 20,
   localparam int unsigned TAG_W  = VA_W - MSK_LSB,
   localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   idx,
   input  logic [MSK_W-1:0]   w_mask,
   input  logic [TAG_W-1:0]   w_tag,
   input  logic [PFN_W-1:0]   w_epfn,
   input  logic               w_ev,
   input  logic [PFN_W-1:0]   w_opfn,
   input  logic               w_ov,
   input  logic [TAG_W-1:0]   va_tag,
   output logic [ENTRIES-1:0] match,
   output logic [MSK_W-1:0]   e_mask [ENTRIES],
   output logic [PFN_W-1:0]   e_epfn [ENTRIES],
   output logic               e_ev   [ENTRIES],
   output logic [PFN_W-1:0]   e_opfn [ENTRIES],
   output logic               e_ov   [ENTRIES],
   output logic [MSK_W-1:0]   r_mask,
   output logic [TAG_W-1:0]   r_tag,
   output logic [PFN_W-1:0]   r_epfn,
   output logic               r_ev,
   output logic [PFN_W-1:0]   r_opfn,
   output logic               r_ov
);
   localparam int unsigned HI_W = TAG_W - MSK_W;

   logic [TAG_W-1:0] e_tag [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic [MSK_W-1:0] q_mask;
      logic [TAG_W-1:0] q_tag;
      logic [PFN_W-1:0] q_epfn, q_opfn;
      logic             q_ev, q_ov;
      logic [TAG_W-1:0] care;
      logic             sel_me;

      assign sel_me = wr_en && (idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_mask <= '0;
            q_tag  <= '0;
            q_epfn <= '0;
            q_ev   <= 1'b0;
            q_opfn <= '0;
            q_ov   <= 1'b0;
         end else if (sel_me) begin
            q_mask <= w_mask;
            q_tag  <= w_tag;
            q_epfn <= w_epfn;
            q_ev   <= w_ev;
            q_opfn <= w_opfn;
            q_ov   <= w_ov;
         end
      end

      // address bits above the mask field always take part in the compare
      assign care     = {{HI_W{1'b1}}, ~q_mask};
      assign match[g] = ((q_tag ^ va_tag) & care) == '0;

      assign e_mask[g] = q_mask;
      assign e_tag[g]  = q_tag;
      assign e_epfn[g] = q_epfn;
      assign e_ev[g]   = q_ev;
      assign e_opfn[g] = q_opfn;
      assign e_ov[g]   = q_ov;
   end

   assign r_mask = e_mask[idx];
   assign r_tag  = e_tag[idx];
   assign r_epfn = e_epfn[idx];
   assign r_ev   = e_ev[idx];
   assign r_opfn = e_opfn[idx];
   assign r_ov   = e_ov[idx];
endmodule

// File: rtl/vpt_pick.sv
module vpt_pick
   import vpt_pkg::*;
#(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned PFN_W   = 20
) (
   input  logic [ENTRIES-1:0] match,
   input  logic [MSK_W-1:0]   e_mask [ENTRIES],
   input  logic [PFN_W-1:0]   e_epfn [ENTRIES],
   input  logic               e_ev   [ENTRIES],
   input  logic [PFN_W-1:0]   e_opfn [ENTRIES],
   input  logic               e_ov   [ENTRIES],
   output logic               hit,
   output logic [MSK_W-1:0]   p_mask,
   output logic [PFN_W-1:0]   p_epfn,
   output logic               p_ev,
   output logic [PFN_W-1:0]   p_opfn,
   output logic               p_ov
);
   logic [ENTRIES-1:0] first;

   // isolate the lowest set bit: lowest index wins
   assign first = match & (~match + ENTRIES'(1));
   assign hit   = |match;

   always_comb begin
      p_mask = '0;
      p_epfn = '0;
      p_ev   = 1'b0;
      p_opfn = '0;
      p_ov   = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         p_mask = p_mask | (e_mask[i] & {MSK_W{first[i]}});
         p_epfn = p_epfn | (e_epfn[i] & {PFN_W{first[i]}});
         p_ev   = p_ev   | (e_ev[i]   & first[i]);
         p_opfn = p_opfn | (e_opfn[i] & {PFN_W{first[i]}});
         p_ov   = p_ov   | (e_ov[i]   & first[i]);
      end
   end
endmodule

// File: rtl/vpt_xlate.sv
module vpt_xlate
   import vpt_pkg::*;
#(
   parameter int unsigned PFN_W = 20,
   localparam int unsigned PA_W = PFN_W + PG_OFF_W,
   localparam int unsigned LO_W = MSK_LSB + MSK_W
) (
   input  logic [LO_W-1:0]  va_lo,
   input  logic             hit,
   input  logic [MSK_W-1:0] mask,
   input  logic [PFN_W-1:0] epfn,
   input  logic             ev,
   input  logic [PFN_W-1:0] opfn,
   input  logic             ov,
   output logic [PA_W-1:0]  pa,
   output logic             valid
);
   localparam int unsigned OFF_MAX = PG_OFF_W + MSK_W;

   logic             odd;
   logic [PFN_W-1:0] pfn;
   logic             pv;
   logic [PA_W-1:0]  offm, frame, va_ext;

   always_comb begin
      // the pair select sits just above the widest passed-through offset bit
      odd = va_lo[PG_OFF_W];
      for (int j = 0; j < MSK_W; j++) begin
         if (mask[j]) odd = va_lo[MSK_LSB + j];
      end
   end

   assign pfn = odd ? opfn : epfn;
   assign pv  = odd ? ov   : ev;

   always_comb begin
      offm = '0;
      offm[PG_OFF_W-1:0]       = '1;
      offm[PG_OFF_W +: MSK_W]  = mask;
      va_ext = '0;
      va_ext[OFF_MAX-1:0]      = va_lo[OFF_MAX-1:0];
   end

   assign frame = {pfn, {PG_OFF_W{1'b0}}};
   assign pa    = hit ? ((frame & ~offm) | (va_ext & offm)) : '0;
   assign valid = hit & pv;
endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
   import vpt_pkg::*;
#(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned VA_W    = 32,
   parameter int unsigned PFN_W   = 20,
   localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int unsigned TAG_W  = VA_W - MSK_LSB,
   localparam int unsigned PA_W   = PFN_W + PG_OFF_W,
   localparam int unsigned LO_W   = MSK_LSB + MSK_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_sel,
   input  logic [VA_W-1:0]  cfg_wdata,
   output logic [VA_W-1:0]  cfg_rdata,
   input  logic             tlb_wr,
   input  logic             tlb_rd,
   input  logic [IDX_W-1:0] tlb_idx,
   input  logic [VA_W-1:0]  lk_va,
   output logic             lk_hit,
   output logic             lk_valid,
   output logic [PA_W-1:0]  lk_pa
);
   // elaboration-time parameter checks
   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("vpt_tlb: ENTRIES must be a power of two, at least 2");
   end
   if (VA_W <= LO_W) begin : g_bad_va
      $error("vpt_tlb: VA_W must leave tag bits above the mask field");
   end
   if (PA_W < LO_W || PFN_W + 1 > VA_W) begin : g_bad_pfn
      $error("vpt_tlb: PFN_W must cover the largest page and fit the data port");
   end

   logic [MSK_W-1:0]   stg_mask;
   logic [TAG_W-1:0]   stg_tag;
   logic [PFN_W-1:0]   stg_epfn, stg_opfn;
   logic               stg_ev, stg_ov;

   logic [MSK_W-1:0]   rd_mask;
   logic [TAG_W-1:0]   rd_tag;
   logic [PFN_W-1:0]   rd_epfn, rd_opfn;
   logic               rd_ev, rd_ov;

   logic [ENTRIES-1:0] match_vec;
   logic [MSK_W-1:0]   ent_mask [ENTRIES];
   logic [PFN_W-1:0]   ent_epfn [ENTRIES];
   logic               ent_ev   [ENTRIES];
   logic [PFN_W-1:0]   ent_opfn [ENTRIES];
   logic               ent_ov   [ENTRIES];

   logic               any_hit;
   logic [MSK_W-1:0]   sel_mask;
   logic [PFN_W-1:0]   sel_epfn, sel_opfn;
   logic               sel_ev, sel_ov;

   vpt_stage #(.VA_W(VA_W), .PFN_W(PFN_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .ld_en     (tlb_rd),
      .ld_mask   (rd_mask),
      .ld_tag    (rd_tag),
      .ld_epfn   (rd_epfn),
      .ld_ev     (rd_ev),
      .ld_opfn   (rd_opfn),
      .ld_ov     (rd_ov),
      .stg_mask  (stg_mask),
      .stg_tag   (stg_tag),
      .stg_epfn  (stg_epfn),
      .stg_ev    (stg_ev),
      .stg_opfn  (stg_opfn),
      .stg_ov    (stg_ov)
   );

   vpt_bank #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PFN_W(PFN_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (tlb_wr),
      .idx    (tlb_idx),
      .w_mask (stg_mask),
      .w_tag  (stg_tag),
      .w_epfn (stg_epfn),
      .w_ev   (stg_ev),
      .w_opfn (stg_opfn),
      .w_ov   (stg_ov),
      .va_tag (lk_va[VA_W-1:MSK_LSB]),
      .match  (match_vec),
      .e_mask (ent_mask),
      .e_epfn (ent_epfn),
      .e_ev   (ent_ev),
      .e_opfn (ent_opfn),
      .e_ov   (ent_ov),
      .r_mask (rd_mask),
      .r_tag  (rd_tag),
      .r_epfn (rd_epfn),
      .r_ev   (rd_ev),
      .r_opfn (rd_opfn),
      .r_ov   (rd_ov)
   );

   vpt_pick #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_pick (
      .match  (match_vec),
      .e_mask (ent_mask),
      .e_epfn (ent_epfn),
      .e_ev   (ent_ev),
      .e_opfn (ent_opfn),
      .e_ov   (ent_ov),
      .hit    (any_hit),
      .p_mask (sel_mask),
      .p_epfn (sel_epfn),
      .p_ev   (sel_ev),
      .p_opfn (sel_opfn),
      .p_ov   (sel_ov)
   );

   vpt_xlate #(.PFN_W(PFN_W)) u_xlate (
      .va_lo (lk_va[LO_W-1:0]),
      .hit   (any_hit),
      .mask  (sel_mask),
      .epfn  (sel_epfn),
      .ev    (sel_ev),
      .opfn  (sel_opfn),
      .ov    (sel_ov),
      .pa    (lk_pa),
      .valid (lk_valid)
   );

   assign lk_hit = any_hit;
endmodule

// File: rtl/vpt_tlb_chk.sv
module vpt_tlb_chk
   import vpt_pkg::*;
#(
   parameter int unsigned VA_W  = 32,
   parameter int unsigned PFN_W = 20,
   localparam int unsigned TAG_W = VA_W - MSK_LSB,
   localparam int unsigned PA_W  = PFN_W + PG_OFF_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [1:0]       cfg_sel,
   input logic [VA_W-1:0]  cfg_wdata,
   input logic             tlb_rd,
   input logic [VA_W-1:0]  lk_va,
   input logic             lk_hit,
   input logic             lk_valid,
   input logic [PA_W-1:0]  lk_pa,
   input logic [MSK_W-1:0] stg_mask,
   input logic [TAG_W-1:0] stg_tag,
   input logic [MSK_W-1:0] rd_mask,
   input logic [TAG_W-1:0] rd_tag
);
   assert_valid_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> lk_hit);

   assert_miss_is_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (!lk_valid && lk_pa == '0));

   assert_offset_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_pa[PG_OFF_W-1:0] == lk_va[PG_OFF_W-1:0]));

   assert_stage_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 2'd0 && !tlb_rd)
         |=> stg_mask == $past(cfg_wdata[MSK_LSB +: MSK_W]));

   assert_stage_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we && !tlb_rd) |=> ($stable(stg_mask) && $stable(stg_tag)));

   assert_read_copies_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_rd |=> (stg_mask == $past(rd_mask) && stg_tag == $past(rd_tag)));
endmodule

bind vpt_tlb vpt_tlb_chk #(.VA_W(VA_W), .PFN_W(PFN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_sel   (cfg_sel),
   .cfg_wdata (cfg_wdata),
   .tlb_rd    (tlb_rd),
   .lk_va     (lk_va),
   .lk_hit    (lk_hit),
   .lk_valid  (lk_valid),
   .lk_pa     (lk_pa),
   .stg_mask  (stg_mask),
   .stg_tag   (stg_tag),
   .rd_mask   (rd_mask),
   .rd_tag    (rd_tag)
);

// File: tb/vpt_tlb_tb_top.sv
module vpt_tlb_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N_ENT      = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [1:0]  cfg_sel;
   logic [31:0] cfg_wdata;
   logic [31:0] cfg_rdata;
   logic        tlb_wr, tlb_rd;
   logic [2:0]  tlb_idx;
   logic [31:0] lk_va;
   logic        lk_hit, lk_valid;
   logic [31:0] lk_pa;

   always #(CLK_PERIOD/2) clk = ~clk;

   vpt_tlb dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tlb_wr(tlb_wr),
      .tlb_rd(tlb_rd), .tlb_idx(tlb_idx), .lk_va(lk_va), .lk_hit(lk_hit),
      .lk_valid(lk_valid), .lk_pa(lk_pa)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // bench model of the entries, built from the requirements
   int unsigned m_k    [N_ENT];
   logic [31:0] m_tag  [N_ENT];
   logic [19:0] m_epfn [N_ENT];
   logic [19:0] m_opfn [N_ENT];
   logic        m_ev   [N_ENT];
   logic        m_ov   [N_ENT];

   task automatic chk(bit ok, string req, string what, longint act, longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   function automatic logic [31:0] mask_word(int unsigned k);
      return ((32'd1 << (2*k)) - 32'd1) << 13;
   endfunction

   task automatic exp_look(input logic [31:0] va, output bit h, output bit v,
                           output logic [31:0] pa);
      longint unsigned page, pair, pfn;
      bit odd;
      h = 0; v = 0; pa = '0;
      for (int i = 0; i < N_ENT; i++) begin
         if (!h) begin
            page = 64'd4096 << (2*m_k[i]);
            pair = 2*page;
            if ((longint'(va) / pair) == (longint'(m_tag[i]) / pair)) begin
               h   = 1;
               odd = ((longint'(va) / page) % 2) == 1;
               pfn = odd ? longint'(m_opfn[i]) : longint'(m_epfn[i]);
               v   = odd ? m_ov[i] : m_ev[i];
               pa  = 32'(((pfn*4096) / page)*page + longint'(va) % page);
            end
         end
      end
   endtask

   task automatic look_chk(logic [31:0] va, string req);
      bit eh, ev;
      logic [31:0] ep;
      @(negedge clk);
      lk_va = va;
      #1;
      exp_look(va, eh, ev, ep);
      chk(lk_hit == eh,   req, "hit",   longint'(lk_hit),   longint'(eh));
      chk(lk_valid == ev, req, "valid", longint'(lk_valid), longint'(ev));
      chk(lk_pa == ep,    req, "pa",    longint'(lk_pa),    longint'(ep));
   endtask

   task automatic stg_write(logic [1:0] s, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic read_chk(logic [1:0] s, logic [31:0] expv, string req);
      cfg_sel = s;
      #1;
      chk(cfg_rdata == expv, req, "cfg_rdata", longint'(cfg_rdata), longint'(expv));
   endtask

   task automatic stage_entry(int unsigned k, logic [31:0] tag, logic [19:0] ep,
                              logic e_v, logic [19:0] op, logic o_v);
      stg_write(2'd0, mask_word(k));
      stg_write(2'd1, tag);
      stg_write(2'd2, {11'd0, ep, e_v});
      stg_write(2'd3, {11'd0, op, o_v});
   endtask

   task automatic model_set(int idx, int unsigned k, logic [31:0] tag, logic [19:0] ep,
                            logic e_v, logic [19:0] op, logic o_v);
      m_k[idx] = k; m_tag[idx] = tag & 32'hFFFF_E000;
      m_epfn[idx] = ep; m_ev[idx] = e_v; m_opfn[idx] = op; m_ov[idx] = o_v;
   endtask

   task automatic load_entry(int idx, int unsigned k, logic [31:0] tag, logic [19:0] ep,
                             logic e_v, logic [19:0] op, logic o_v);
      stage_entry(k, tag, ep, e_v, op, o_v);
      @(negedge clk);
      tlb_wr = 1'b1; tlb_idx = 3'(idx);
      @(negedge clk);
      tlb_wr = 1'b0;
      model_set(idx, k, tag, ep, e_v, op, o_v);
   endtask

   task automatic tlb_read(int idx);
      @(negedge clk);
      tlb_rd = 1'b1; tlb_idx = 3'(idx);
      @(negedge clk);
      tlb_rd = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
      tlb_wr = 0; tlb_rd = 0; tlb_idx = 0; lk_va = 0;
      for (int i = 0; i < N_ENT; i++) model_set(i, 0, 32'd0, 20'd0, 1'b0, 20'd0, 1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int s = 0; s < 4; s++) read_chk(2'(s), 32'd0, "R1");
      look_chk(32'h0000_1ABC, "R1");
      look_chk(32'h8000_0000, "R1");

      // R2: field layout, unused bits read as zero
      stg_write(2'd0, 32'hFFFF_FFFF); read_chk(2'd0, 32'h01FF_E000, "R2");
      stg_write(2'd1, 32'hFFFF_FFFF); read_chk(2'd1, 32'hFFFF_E000, "R2");
      stg_write(2'd2, 32'hFFFF_FFFF); read_chk(2'd2, 32'h001F_FFFF, "R2");
      stg_write(2'd3, 32'hFFFF_FFFF); read_chk(2'd3, 32'h001F_FFFF, "R2");
      // R3: staging alone does not change entries
      look_chk(32'h0000_0010, "R3");

      // R5 R6 R7 R8: one entry per page size, with junk below each pair boundary
      for (int i = 0; i < N_ENT; i++) begin
         logic [31:0] tg;
         tg = (32'(i + 1) << 25) | ((32'h5A3C_1F37 * 32'(i + 3)) & 32'h01FF_FFFF);
         load_entry(i, i % 7, tg, 20'h10000 + 20'(i * 'h111), 1'b1,
                    20'h20000 + 20'(i * 'h222), (i != 3));
      end

      // R3 R4: read every entry back through staging
      for (int i = 0; i < N_ENT; i++) begin
         tlb_read(i);
         read_chk(2'd0, mask_word(m_k[i]), "R4");
         read_chk(2'd1, m_tag[i], "R3");
         read_chk(2'd2, {11'd0, m_epfn[i], m_ev[i]}, "R4");
         read_chk(2'd3, {11'd0, m_opfn[i], m_ov[i]}, "R4");
      end

      // R6 R7: page-edge probes for every size
      for (int i = 0; i < N_ENT; i++) begin
         longint unsigned page, base;
         page = 64'd4096 << (2*m_k[i]);
         base = (longint'(m_tag[i]) / (2*page)) * (2*page);
         look_chk(32'(base), "R6");
         look_chk(32'(base + page - 1), "R7");
         look_chk(32'(base + page), "R6");
         look_chk(32'(base + 2*page - 1), "R8");
         look_chk(32'(base + 2*page), "R5");
         look_chk(32'(base + page/2 + 'h123), "R7");
      end

      // R5 R9: randomized addresses over all pair regions plus a missing one
      lfsr = 32'hACE1_2469;
      for (int n = 0; n < 1500; n++) begin
         lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
         look_chk({7'((lfsr[31:28] % 9) + 1), lfsr[24:0]}, "R5");
      end

      // R10: overlapping entries, lowest index wins
      load_entry(6, m_k[2], m_tag[2], 20'hBEEF0, 1'b1, 20'hBEEF1, 1'b1);
      look_chk(m_tag[2] | 32'h0000_0123, "R10");
      look_chk(m_tag[2] | 32'h0000_1123, "R10");
      load_entry(1, m_k[5], m_tag[5], 20'hCAFE0, 1'b1, 20'hCAFE1, 1'b1);
      look_chk(m_tag[5] & 32'hFE00_0000, "R10");
      look_chk((m_tag[5] & 32'hFE00_0000) | 32'h0040_0000, "R10");

      // R4: a read wins over a port write in the same cycle
      @(negedge clk);
      tlb_rd = 1'b1; tlb_idx = 3'd2;
      cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'd0;
      @(negedge clk);
      tlb_rd = 1'b0; cfg_we = 1'b0;
      read_chk(2'd0, mask_word(m_k[2]), "R4");
      read_chk(2'd1, m_tag[2], "R4");

      // R11: new entry visible straight after its write edge
      stage_entry(0, 32'h7000_0000, 20'h77770, 1'b1, 20'h77771, 1'b1);
      @(negedge clk);
      lk_va = 32'h7000_1234;
      #1;
      chk(lk_hit == 1'b0, "R11", "hit before write", longint'(lk_hit), 0);
      tlb_wr = 1'b1; tlb_idx = 3'd0;
      @(posedge clk);
      #1;
      tlb_wr = 1'b0;
      chk(lk_hit == 1'b1, "R11", "hit after write", longint'(lk_hit), 1);
      chk(lk_pa == 32'h7777_1234, "R11", "pa after write", longint'(lk_pa), 32'h7777_1234);
      model_set(0, 0, 32'h7000_0000, 20'h77770, 1'b1, 20'h77771, 1'b1);
      look_chk(32'h7000_0FFF, "R11");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule